// File: doc/BRIEF.md
# Indirect Pattern RAM Loader

This block owns a small pattern RAM that is never placed in the host's address map. The host reaches it through four registers: a mode register, a data register, and a base and mask pair that define a decoded address window. The mode register holds an operation code and the current array index. The data register is the only path to and from the RAM.

To load the RAM, the host selects the write-array operation and writes a word into the data register. It then makes any write inside the window. That write moves the data register into the RAM at the current index, and the index steps forward. Reading back works the other way. The host selects the read-array operation and makes a read inside the window. That read copies the RAM word at the current index into the data register and steps the index. The host then reads the data register. In normal operation, window accesses leave the RAM and the index alone.

The host bus carries one outstanding access at a time. Every access is answered by a one-cycle acknowledge. The host must wait for that acknowledge before it starts the next access.

Top module: `mrl_loader`

## Requirements
- R1: After reset, the mode register reads zero (normal operation, index 0), the data, base and mask registers read zero, and the window is disabled.
- R2: The registers sit at REG_BASE plus byte offsets 0x0 (mode), 0x4 (data), 0x8 (base) and 0xC (mask). The data, base and mask registers read back the full 32-bit value last written. The mode register reads back its operation field in bits [1:0] and its 6-bit index in bits [13:8], with all other bits zero.
- R3: An access hits the window only when base bit 0 (the enable) is 1 and the access address ANDed with the mask equals the base, with bit 0 cleared, ANDed with the mask. A register-range access never counts as a window access.
- R4: With operation code 1 (write-array), a window write stores the data register into the RAM at the current index and ignores the bus write data. The index then increments.
- R5: With operation code 2 (read-array), a window read loads the RAM word at the current index into the data register. The index increments, and the same word is returned on the bus.
- R6: The index wraps from 63 to 0 when it increments.
- R7: With operation code 0 or 3 (normal), a window read returns all ones, a window write is ignored, and the RAM, the data register and the index stay unchanged.
- R8: In write-array mode, a window read returns all ones and leaves the index unchanged. In read-array mode, a window write leaves the RAM, the data register and the index unchanged.
- R9: An access that hits neither the registers nor the window changes no state, and a read of that kind returns zero.
- R10: Writing the mode register sets the operation and the index together, so the next transfer starts at the written index.
- R11: Every access is acknowledged exactly one cycle after its request, except a read-array window read, which is acknowledged two cycles after its request.
- R12: A register write is in effect for the very next access, including a window transfer issued right after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access completion |

## Verification
The bench fills all 64 entries with distinct words and drives the bus write data with the complement of each word. A design that stored bus data instead of the data register would then read back inverted words. The bench also ends every pass on the wrapped index. A design whose index saturated, or ran past 63, would show a wrong index in the mode register.

Each access kind is tried in each mode: window reads in normal and write-array mode, window writes in read-array mode, and accesses just outside the window or made with the enable cleared. Each of these is followed by a mode read and a read-array pass. Together they expose a design that moves the index or touches the RAM when it should not. Read-array latency and back-to-back register-then-window sequences are timed. A design that returned the data register before the RAM word landed would return the previous word.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic [1:0] {
    OP_NORMAL = 2'd0,
    OP_WR_ARR = 2'd1,
    OP_RD_ARR = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BASE = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  localparam int MODE_IDX_LSB = 8;
endpackage

// File: rtl/mrl_regs.sv
module mrl_regs
  import mrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  reg_sel_e          rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              idx_inc,
  input  logic              data_load,
  input  logic [DATA_W-1:0] load_val,
  output op_e               op,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] data,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] mask
);
  op_e               op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] mask_q;

  // Mode register: operation and index are written together
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_NORMAL;
      idx_q <= '0;
    end else if (wr_en && wr_sel == SEL_MODE) begin
      op_q  <= op_e'(wr_data[1:0]);
      idx_q <= wr_data[MODE_IDX_LSB +: IDX_W];
    end else if (idx_inc) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (wr_en && wr_sel == SEL_DATA) begin
      data_q <= wr_data;
    end else if (data_load) begin
      data_q <= load_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_BASE) base_q <= ADDR_W'(wr_data);
      if (wr_sel == SEL_MASK) mask_q <= ADDR_W'(wr_data);
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_sel)
      SEL_MODE: begin
        rd_data[1:0] = op_q;
        rd_data[MODE_IDX_LSB +: IDX_W] = idx_q;
      end
      SEL_DATA: rd_data = data_q;
      SEL_BASE: rd_data = DATA_W'(base_q);
      SEL_MASK: rd_data = DATA_W'(mask_q);
      default:  rd_data = '0;
    endcase
  end

  assign op   = op_q;
  assign idx  = idx_q;
  assign data = data_q;
  assign base = base_q;
  assign mask = mask_q;
endmodule

// File: rtl/mrl_win_dec.sv
module mrl_win_dec #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic              hit
);
  logic [ADDR_W-1:0] base_cmp;

  always_comb begin
    base_cmp = {base[ADDR_W-1:1], 1'b0};
    hit = base[0] && ((addr & mask) == (base_cmp & mask));
  end
endmodule

// File: rtl/mrl_pat_ram.sv
module mrl_pat_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/mrl_loader.sv
module mrl_loader
  import mrl_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 32,
  parameter int          DEPTH    = 64,
  parameter logic [31:0] REG_BASE = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack
);
  localparam int IDX_W = $clog2(DEPTH);

  op_e               op_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] mask_q;
  logic [DATA_W-1:0] reg_rdata;
  logic [DATA_W-1:0] ram_dout;
  logic              win_dec_hit;
  logic              accept;
  logic              reg_hit;
  logic              win_hit;
  logic              ram_we;
  logic              ram_re;
  logic              load_pend_q;
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] resp;

  // One access at a time: requests during a pending load are not taken
  assign accept  = bus_req && !load_pend_q;
  assign reg_hit = bus_req && (bus_addr[ADDR_W-1:4] == REG_BASE[ADDR_W-1:4]);
  assign win_hit = bus_req && !reg_hit && win_dec_hit;
  assign ram_we  = accept && win_hit && bus_we && (op_q == OP_WR_ARR);
  assign ram_re  = accept && win_hit && !bus_we && (op_q == OP_RD_ARR);

  mrl_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept && reg_hit && bus_we),
    .wr_sel   (reg_sel_e'(bus_addr[3:2])),
    .wr_data  (bus_wdata),
    .rd_sel   (reg_sel_e'(bus_addr[3:2])),
    .rd_data  (reg_rdata),
    .idx_inc  (ram_we || ram_re),
    .data_load(load_pend_q),
    .load_val (ram_dout),
    .op       (op_q),
    .idx      (idx_q),
    .data     (data_q),
    .base     (base_q),
    .mask     (mask_q)
  );

  mrl_win_dec #(
    .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr),
    .base(base_q),
    .mask(mask_q),
    .hit (win_dec_hit)
  );

  mrl_pat_ram #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .idx  (idx_q),
    .wdata(data_q),
    .rdata(ram_dout)
  );

  always_comb begin
    resp = '0;
    if (!bus_we) begin
      if (reg_hit)      resp = reg_rdata;
      else if (win_hit) resp = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pend_q <= 1'b0;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      load_pend_q <= ram_re;
      ack_q       <= 1'b0;
      if (load_pend_q) begin
        ack_q   <= 1'b1;
        rdata_q <= ram_dout;
      end else if (accept && !ram_re) begin
        ack_q   <= 1'b1;
        rdata_q <= resp;
      end
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/mrl_loader_chk.sv
module mrl_loader_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              reg_hit,
  input logic              win_hit,
  input logic [1:0]        op_q,
  input logic [IDX_W-1:0]  idx_q,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] ram_dout,
  input logic              ram_we,
  input logic              ram_re,
  input logic              load_pend_q
);
  // R11: an acknowledge always answers a request or a completed load
  a_r11_ack_cause: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (($past(bus_req) && !$past(ram_re)) || $past(load_pend_q)));

  // R6: each RAM transfer advances the index by one, wrapping
  a_r6_idx_step: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  // R7: RAM writes occur only in write-array mode
  a_r7_no_write_outside_wr: assert property (@(posedge clk) disable iff (rst)
    (op_q != 2'd1) |-> !ram_we);

  // R7: RAM reads occur only in read-array mode
  a_r7_no_read_outside_rd: assert property (@(posedge clk) disable iff (rst)
    (op_q != 2'd2) |-> !ram_re);

  // R5: the data register takes the RAM word after a read-array load
  a_r5_load_data: assert property (@(posedge clk) disable iff (rst)
    load_pend_q |=> (data_q == $past(ram_dout)));

  // R9: an access hitting nothing changes neither index nor data
  a_r9_miss_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !load_pend_q && !reg_hit && !win_hit) |=>
      ($stable(idx_q) && $stable(data_q)));
endmodule

bind mrl_loader mrl_loader_chk #(
  .DATA_W(DATA_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_ack    (bus_ack),
  .reg_hit    (reg_hit),
  .win_hit    (win_hit),
  .op_q       (op_q),
  .idx_q      (idx_q),
  .data_q     (data_q),
  .ram_dout   (ram_dout),
  .ram_we     (ram_we),
  .ram_re     (ram_re),
  .load_pend_q(load_pend_q)
);

// File: tb/tb_mrl_loader.sv
module tb_mrl_loader;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] REGB  = 32'hF000_0000;
  localparam logic [31:0] R_MODE = REGB + 32'h0;
  localparam logic [31:0] R_DATA = REGB + 32'h4;
  localparam logic [31:0] R_BASE = REGB + 32'h8;
  localparam logic [31:0] R_MASK = REGB + 32'hC;
  localparam logic [31:0] WIN   = 32'hE240_0000;
  localparam logic [31:0] WMASK = 32'hFFFF_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrl_loader dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  function automatic logic [31:0] pat(int i);
    return (32'(i) * 32'h9E37_79B9) ^ 32'hC001_0F0F;
  endfunction

  function automatic logic [31:0] mode(int op, int idx);
    return (32'(idx) << 8) | 32'(op);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    lat = 1;
    while (!bus_ack && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = bus_rdata;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r; int l;
    access(1'b1, a, d, r, l);
  endtask

  task automatic rd_exp(input logic [31:0] a, input logic [31:0] e, input string tag);
    logic [31:0] r; int l;
    access(1'b0, a, 32'h0, r, l);
    chk(r == e, tag, r, e);
  endtask

  task automatic t_reset;
    rd_exp(R_MODE, 32'h0, "R1 mode");
    rd_exp(R_DATA, 32'h0, "R1 data");
    rd_exp(R_BASE, 32'h0, "R1 base");
    rd_exp(R_MASK, 32'h0, "R1 mask");
    rd_exp(WIN, 32'h0, "R1 window off");
  endtask

  task automatic t_regs;
    wr(R_MODE, 32'hFFFF_FFFF);
    rd_exp(R_MODE, 32'h0000_3F03, "R2 mode fields");
    wr(R_DATA, 32'h8765_4321);
    rd_exp(R_DATA, 32'h8765_4321, "R2 data");
    wr(R_BASE, 32'h1234_5677);
    rd_exp(R_BASE, 32'h1234_5677, "R2 base");
    wr(R_MASK, 32'hA5A5_5A5A);
    rd_exp(R_MASK, 32'hA5A5_5A5A, "R2 mask");
    wr(R_MODE, 32'h0);
    wr(R_BASE, WIN | 32'h1);
    wr(R_MASK, WMASK);
  endtask

  task automatic t_load;
    wr(R_MODE, mode(1, 0));
    for (int i = 0; i < 64; i++) begin
      wr(R_DATA, pat(i));
      wr(WIN + 32'(i) * 4, ~pat(i));
    end
    rd_exp(R_MODE, mode(1, 0), "R6 index wrapped after load");
  endtask

  task automatic t_readback;
    int bad = 0;
    wr(R_MODE, mode(2, 0));
    for (int i = 0; i < 64; i++) begin
      logic [31:0] r; int l;
      access(1'b0, WIN + 32'h100, 32'h0, r, l);
      if (r != pat(i) || l != 2) begin
        bad++;
        chk(1'b0, "R4/R5 window read word", r, pat(i));
        chk(1'b0, "R11 read-array latency", 32'(l), 32'd2);
      end
      access(1'b0, R_DATA, 32'h0, r, l);
      if (r != pat(i) || l != 1) begin
        bad++;
        chk(1'b0, "R5 data register", r, pat(i));
      end
    end
    chk(bad == 0, "R4 R5 full readback", 32'(bad), 32'd0);
    rd_exp(R_MODE, mode(2, 0), "R6 index wrapped after readback");
  endtask

  task automatic t_restart;
    logic [31:0] r; int l;
    wr(R_MODE, mode(2, 5));
    access(1'b0, WIN, 32'h0, r, l);
    chk(r == pat(5), "R10 restart at index 5", r, pat(5));
    chk(l == 2, "R11 read-array latency", 32'(l), 32'd2);
    rd_exp(R_MODE, mode(2, 6), "R10 index advanced");
  endtask

  task automatic t_normal;
    logic [31:0] r; int l;
    wr(R_MODE, mode(0, 7));
    wr(R_DATA, 32'h0000_1234);
    wr(WIN + 32'h40, 32'hFFFF_0000);
    access(1'b0, WIN + 32'h40, 32'h0, r, l);
    chk(r == 32'hFFFF_FFFF, "R7 normal read all ones", r, 32'hFFFF_FFFF);
    chk(l == 1, "R11 normal latency", 32'(l), 32'd1);
    rd_exp(R_MODE, mode(0, 7), "R7 index kept");
    rd_exp(R_DATA, 32'h0000_1234, "R7 data kept");
    wr(R_MODE, mode(3, 7));
    rd_exp(WIN, 32'hFFFF_FFFF, "R7 reserved op reads all ones");
    wr(R_MODE, mode(2, 7));
    rd_exp(WIN, pat(7), "R7 RAM untouched");
  endtask

  task automatic t_cross;
    wr(R_MODE, mode(1, 3));
    rd_exp(WIN, 32'hFFFF_FFFF, "R8 read in write-array");
    rd_exp(R_MODE, mode(1, 3), "R8 index kept in write-array");
    wr(R_MODE, mode(2, 4));
    wr(R_DATA, 32'h0000_DEAD);
    wr(WIN, 32'h0000_BEEF);
    rd_exp(R_MODE, mode(2, 4), "R8 index kept in read-array");
    rd_exp(R_DATA, 32'h0000_DEAD, "R8 data kept");
    rd_exp(WIN, pat(4), "R8 RAM untouched");
  endtask

  task automatic t_outside;
    wr(R_MODE, mode(1, 9));
    wr(R_DATA, 32'h0000_0055);
    wr(WIN + 32'h8000, 32'h0);
    rd_exp(WIN + 32'h8000, 32'h0, "R9 outside read zero");
    rd_exp(R_MODE, mode(1, 9), "R9 index kept");
    wr(R_BASE, WIN);
    wr(WIN, 32'h0);
    rd_exp(R_MODE, mode(1, 9), "R3 disabled window no step");
    rd_exp(WIN, 32'h0, "R3 disabled window read zero");
    wr(R_BASE, WIN | 32'h1);
    wr(R_MODE, mode(2, 9));
    rd_exp(WIN, pat(9), "R9 RAM untouched");
    wr(R_MODE, mode(2, 11));
    rd_exp(WIN + 32'h7FFC, pat(11), "R3 top of window hits");
  endtask

  task automatic t_back2back;
    wr(R_MODE, mode(1, 10));
    wr(R_DATA, 32'hCAFE_F00D);
    wr(WIN, 32'h0);
    wr(R_MODE, mode(2, 10));
    rd_exp(WIN, 32'hCAFE_F00D, "R12 write then window at once");
    rd_exp(R_DATA, 32'hCAFE_F00D, "R12 data register loaded");
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_load();
    t_readback();
    t_restart();
    t_normal();
    t_cross();
    t_outside();
    t_back2back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule